// File: doc/BRIEF.md
# Dual-Motor Stepper Phase Sequencer

This block drives the coil phases of two stepping motors, a carriage motor and a paper-feed motor. A host writes a small set of registers to give each motor a direction, a step period and a number of steps. The block then steps the motor on its own and raises a per-motor done flag when the run is complete. Each motor has four phase outputs: A, B, /A and /B.

The carriage channel can energise one winding per step or two windings per step. It also carries a peak-current selection code that goes to an external motor driver. The code has five levels, and the driver uses it to switch its current limit. The paper-feed channel always energises two windings per step.

Step timing comes from an internal timebase tick. The tick fires once every `CLK_PER_TICK` system clocks, which gives an 8 MHz tick from a 16 MHz clock by default. The tick is scaled again by each channel's period register. Changes to the excitation style and to the current level are held pending and applied together with the next step, so the phase outputs never show a pattern that lies between two steps.

Top module: `dual_stepper_seq`

## Requirements
- R1: Carriage phase bits are {/B,/A,B,A} (bit 3 down to bit 0).
  - Two-winding mode walks index 0..3 as 0011, 0110, 1100, 1001.
  - One-winding mode walks index 0..3 as 0001, 0010, 0100, 1000.
- R2: The feed channel always uses the two-winding patterns of R1. Its control bit 2 (mode) has no effect.
- R3: The current field is control bits 6:4. A written value of 5, 6 or 7 is taken as 4, so `car_ilevel` never exceeds 4.
- R4: A new mode or current level written to carriage control appears on `car_phase` and `car_ilevel` only at that channel's next step.
  - Between steps, only a control write can change a channel's phase outputs.
- R5: Control bit 1 chooses direction. At 0, each step raises the sequence index by one, modulo 4. At 1, each step lowers it by one, modulo 4.
- R6: A running channel steps once every P timebase ticks, where P is its period register, and a period of 0 acts as 1. A tick fires every `CLK_PER_TICK` clocks, so steady stepping is P*`CLK_PER_TICK` clocks apart.
- R7: Writing N>0 to a count register runs exactly N steps and then stops.
  - The channel's done output rises with the last step.
  - It stays high until that count register is written again, and the write clears it.
- R8: Control bit 0 enables the channel. While it is 0, the channel's phases are 0000, no step is taken, and the sequence index is kept.
- R9: Register addresses (`wr_addr`) are:

  | Address | Register |
  |---------|----------|
  | 0 | carriage control |
  | 1 | carriage period |
  | 2 | carriage count |
  | 4 | feed control |
  | 5 | feed period |
  | 6 | feed count |

  Writes take effect on the clock edge where `wr_en` is high.
- R10: After reset, both channels are:
  - disabled;
  - in two-winding mode;
  - at index 0, level 0 and count 0;
  - with both done outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| car_phase | output | 4 | Carriage coil drive {/B,/A,B,A} |
| car_ilevel | output | 3 | Carriage peak-current selection, 0 to 4 |
| car_done | output | 1 | Carriage run complete |
| feed_phase | output | 4 | Feed coil drive {/B,/A,B,A} |
| feed_done | output | 1 | Feed run complete |

## Verification
The assertions check, on every cycle:
- the shape of each phase word: one or two windings on the carriage, exactly two on the feed, or none;
- the ceiling on the current code;
- that the phase words and the level move only on a step or a control write;
- that a done flag holds until its count register is rewritten.

Only the bench scenarios can show the rest:
- the order of the patterns in each direction;
- the exact clock spacing between steps;
- the number of steps in a run;
- the index surviving a disable;
- that a mode or level change waits for the next step rather than being lost.

// File: rtl/stp_pkg.sv
package stp_pkg;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 16;
  localparam int LVL_W   = 3;
  localparam int LVL_MAX = 4;

  localparam logic [ADDR_W-1:0] A_CAR_CTL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CAR_PER  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CAR_CNT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_FEED_CTL = 3'd4;
  localparam logic [ADDR_W-1:0] A_FEED_PER = 3'd5;
  localparam logic [ADDR_W-1:0] A_FEED_CNT = 3'd6;

  typedef logic [1:0] idx_t;
  typedef logic [3:0] phase_t;

  // Phase word bit order {/B,/A,B,A}
  function automatic phase_t phase_decode(idx_t idx, logic single);
    logic [7:0] dbl;
    dbl = {4'b0011, 4'b0011} << idx;
    if (single) return phase_t'(4'b0001 << idx);
    return dbl[7:4];
  endfunction
endpackage

// File: rtl/stp_tick_gen.sv
module stp_tick_gen #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/stp_step_timer.sv
module stp_step_timer #(
  parameter int PER_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             per_we,
  input  logic             cnt_we,
  input  logic [PER_W-1:0] per_wdata,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic             step,
  output logic             done
);
  logic [PER_W-1:0] per_q, per_d;
  logic [PER_W-1:0] tmr_q, tmr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic [PER_W-1:0] limit;
  logic             run;

  assign limit = (per_q == '0) ? '0 : per_q - 1'b1;
  assign run   = en && (cnt_q != '0);
  assign step  = run && tick && (tmr_q >= limit);
  assign done  = done_q;

  always_comb begin
    per_d  = per_we ? per_wdata : per_q;
    tmr_d  = tmr_q;
    cnt_d  = cnt_q;
    done_d = done_q;
    if (cnt_we) begin
      cnt_d  = cnt_wdata;
      tmr_d  = '0;
      done_d = 1'b0;
    end else if (step) begin
      cnt_d  = cnt_q - 1'b1;
      tmr_d  = '0;
      done_d = (cnt_q == CNT_W'(1));
    end else if (run && tick) begin
      tmr_d  = tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      tmr_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      per_q  <= per_d;
      tmr_q  <= tmr_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/stp_phase_seq.sv
module stp_phase_seq
  import stp_pkg::*;
#(
  parameter bit SUPPORT_SINGLE = 1'b1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ctl_we,
  input  logic   ctl_en,
  input  logic   ctl_dir,
  input  logic   ctl_single,
  input  logic   step,
  output logic   en,
  output phase_t phase
);
  logic en_q, en_d;
  logic dir_q, dir_d;
  idx_t idx_q, idx_d;
  logic single_act;

  always_comb begin
    en_d  = ctl_we ? ctl_en  : en_q;
    dir_d = ctl_we ? ctl_dir : dir_q;
    idx_d = idx_q;
    if (step) idx_d = dir_q ? idx_q - 1'b1 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      dir_q <= 1'b0;
      idx_q <= '0;
    end else begin
      en_q  <= en_d;
      dir_q <= dir_d;
      idx_q <= idx_d;
    end
  end

  generate
    if (SUPPORT_SINGLE) begin : g_dual_mode
      logic pend_q, pend_d, act_q, act_d;
      always_comb begin
        pend_d = ctl_we ? ctl_single : pend_q;
        act_d  = step ? pend_q : act_q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend_q <= 1'b0;
          act_q  <= 1'b0;
        end else begin
          pend_q <= pend_d;
          act_q  <= act_d;
        end
      end
      assign single_act = act_q;
    end else begin : g_two_only
      logic unused_single;
      assign unused_single = ctl_single;
      assign single_act    = 1'b0;
    end
  endgenerate

  assign en    = en_q;
  assign phase = en_q ? phase_decode(idx_q, single_act) : '0;
endmodule

// File: rtl/stp_level_latch.sv
module stp_level_latch
  import stp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_we,
  input  logic [LVL_W-1:0] lvl_wdata,
  input  logic             step,
  output logic [LVL_W-1:0] level
);
  logic [LVL_W-1:0] pend_q, pend_d, act_q, act_d;
  logic [LVL_W-1:0] clamped;

  assign clamped = (lvl_wdata > LVL_W'(LVL_MAX)) ? LVL_W'(LVL_MAX) : lvl_wdata;

  always_comb begin
    pend_d = lvl_we ? clamped : pend_q;
    act_d  = step ? pend_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign level = act_q;
endmodule

// File: rtl/dual_stepper_seq.sv
module dual_stepper_seq
  import stp_pkg::*;
#(
  parameter int CLK_PER_TICK = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [3:0]        car_phase,
  output logic [LVL_W-1:0]  car_ilevel,
  output logic              car_done,
  output logic [3:0]        feed_phase,
  output logic              feed_done
);
  logic [1:0] rsync_q;
  logic       rst_int_n;
  logic       tick;
  logic       car_en, feed_en;
  logic       car_step, feed_step;
  logic       car_ctl_we, car_per_we, car_cnt_we;
  logic       feed_ctl_we, feed_per_we, feed_cnt_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  assign car_ctl_we  = wr_en && (wr_addr == A_CAR_CTL);
  assign car_per_we  = wr_en && (wr_addr == A_CAR_PER);
  assign car_cnt_we  = wr_en && (wr_addr == A_CAR_CNT);
  assign feed_ctl_we = wr_en && (wr_addr == A_FEED_CTL);
  assign feed_per_we = wr_en && (wr_addr == A_FEED_PER);
  assign feed_cnt_we = wr_en && (wr_addr == A_FEED_CNT);

  stp_tick_gen #(.DIV(CLK_PER_TICK)) u_tick (
    .clk(clk), .rst_n(rst_int_n), .tick(tick)
  );

  stp_step_timer #(.PER_W(DATA_W), .CNT_W(DATA_W)) u_car_tmr (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .en(car_en),
    .per_we(car_per_we), .cnt_we(car_cnt_we),
    .per_wdata(wr_data), .cnt_wdata(wr_data),
    .step(car_step), .done(car_done)
  );

  stp_phase_seq #(.SUPPORT_SINGLE(1'b1)) u_car_seq (
    .clk(clk), .rst_n(rst_int_n), .ctl_we(car_ctl_we),
    .ctl_en(wr_data[0]), .ctl_dir(wr_data[1]), .ctl_single(wr_data[2]),
    .step(car_step), .en(car_en), .phase(car_phase)
  );

  stp_level_latch u_car_lvl (
    .clk(clk), .rst_n(rst_int_n), .lvl_we(car_ctl_we),
    .lvl_wdata(wr_data[6:4]), .step(car_step), .level(car_ilevel)
  );

  stp_step_timer #(.PER_W(DATA_W), .CNT_W(DATA_W)) u_feed_tmr (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .en(feed_en),
    .per_we(feed_per_we), .cnt_we(feed_cnt_we),
    .per_wdata(wr_data), .cnt_wdata(wr_data),
    .step(feed_step), .done(feed_done)
  );

  stp_phase_seq #(.SUPPORT_SINGLE(1'b0)) u_feed_seq (
    .clk(clk), .rst_n(rst_int_n), .ctl_we(feed_ctl_we),
    .ctl_en(wr_data[0]), .ctl_dir(wr_data[1]), .ctl_single(wr_data[2]),
    .step(feed_step), .en(feed_en), .phase(feed_phase)
  );
endmodule

// File: rtl/stp_checker.sv
module stp_checker
  import stp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [3:0]        car_phase,
  input logic [LVL_W-1:0]  car_ilevel,
  input logic              car_done,
  input logic [3:0]        feed_phase,
  input logic              feed_done,
  input logic              car_step,
  input logic              feed_step
);
  assert_car_shape_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (car_phase == 4'b0000) || ($countones(car_phase) == 1) || ($countones(car_phase) == 2));

  assert_feed_two_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (feed_phase == 4'b0000) || ($countones(feed_phase) == 2));

  assert_level_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    car_ilevel <= LVL_W'(LVL_MAX));

  assert_level_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !car_step |=> $stable(car_ilevel));

  assert_car_phase_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!car_step && !(wr_en && wr_addr == A_CAR_CTL)) |=> $stable(car_phase));

  assert_feed_phase_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!feed_step && !(wr_en && wr_addr == A_FEED_CTL)) |=> $stable(feed_phase));

  assert_car_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (car_done && !(wr_en && wr_addr == A_CAR_CNT)) |=> car_done);

  assert_feed_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (feed_done && !(wr_en && wr_addr == A_FEED_CNT)) |=> feed_done);
endmodule

bind dual_stepper_seq stp_checker u_stp_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .car_phase(car_phase), .car_ilevel(car_ilevel), .car_done(car_done),
  .feed_phase(feed_phase), .feed_done(feed_done),
  .car_step(car_step), .feed_step(feed_step)
);

// File: tb/dual_stepper_seq_bench.sv
module dual_stepper_seq_bench;
  localparam int DIV = 2;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [3:0]  car_phase, feed_phase;
  logic [2:0]  car_ilevel;
  logic        car_done, feed_done;

  int n_chk  = 0;
  int n_fail = 0;

  // bench model
  int   c_idx, f_idx;
  logic c_en, c_dir, c_sp, c_sa, f_en, f_dir;
  int   c_lp, c_la;

  dual_stepper_seq #(.CLK_PER_TICK(DIV)) u_dual_stepper_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .car_phase(car_phase), .car_ilevel(car_ilevel), .car_done(car_done),
    .feed_phase(feed_phase), .feed_done(feed_done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [3:0] exp_pat(int idx, logic single, logic en);
    int i;
    i = ((idx % 4) + 4) % 4;
    if (!en) return 4'b0000;
    if (single) begin
      case (i)
        0: return 4'b0001;
        1: return 4'b0010;
        2: return 4'b0100;
        default: return 4'b1000;
      endcase
    end
    case (i)
      0: return 4'b0011;
      1: return 4'b0110;
      2: return 4'b1100;
      default: return 4'b1001;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic car_ctl(logic en, logic dir, logic single, int lvl);
    wr(3'd0, 16'((lvl << 4) | (single << 2) | (dir << 1) | en));
    c_en = en; c_dir = dir; c_sp = single;
    c_lp = (lvl > 4) ? 4 : lvl;
  endtask

  task automatic feed_ctl(logic en, logic dir, logic single);
    wr(3'd4, 16'((single << 2) | (dir << 1) | en));
    f_en = en; f_dir = dir;
  endtask

  task automatic wait_done(bit car, output bit ok);
    ok = 0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (car ? car_done : feed_done) begin ok = 1; break; end
    end
  endtask

  task automatic car_run(int per, int n, string req);
    bit ok;
    wr(3'd1, 16'(per));
    wr(3'd2, 16'(n));
    wait_done(1, ok);
    check({req, " car done"}, ok, 1);
    c_idx += c_dir ? -n : n;
    c_sa = c_sp; c_la = c_lp;
    check({req, " car phase"}, car_phase, exp_pat(c_idx, c_sa, c_en));
    check({req, " car level"}, car_ilevel, c_la);
  endtask

  task automatic feed_run(int per, int n, string req);
    bit ok;
    wr(3'd5, 16'(per));
    wr(3'd6, 16'(n));
    wait_done(0, ok);
    check({req, " feed done"}, ok, 1);
    f_idx += f_dir ? -n : n;
    check({req, " feed phase"}, feed_phase, exp_pat(f_idx, 1'b0, f_en));
  endtask

  // R6: clocks between two consecutive carriage steps
  task automatic car_interval(int per, int n, output int gap);
    logic [3:0] prev;
    int k;
    gap = -1;
    wr(3'd1, 16'(per));
    wr(3'd2, 16'(n));
    prev = car_phase;
    k = 0;
    while (car_phase == prev && k < 2000) begin @(negedge clk); k++; end
    prev = car_phase;
    k = 0;
    while (car_phase == prev && k < 2000) begin @(negedge clk); k++; end
    gap = k;
    while (!car_done && k < 4000) begin @(negedge clk); k++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int gap, seed, per, n;
    bit ok;
    seed = 32'h5eed1234;
    void'($urandom(seed));
    wr_en = 0; wr_addr = 0; wr_data = 0;
    c_idx = 0; f_idx = 0; c_en = 0; c_dir = 0; c_sp = 0; c_sa = 0; f_en = 0; f_dir = 0;
    c_lp = 0; c_la = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check("R10 car_phase", car_phase, 0);
    check("R10 feed_phase", feed_phase, 0);
    check("R10 car_ilevel", car_ilevel, 0);
    check("R10 car_done", car_done, 0);
    check("R10 feed_done", feed_done, 0);

    // R9 R1 enable both, two-winding at index 0
    car_ctl(1, 0, 0, 0);
    feed_ctl(1, 0, 0);
    check("R1 car idx0 two", car_phase, 4'b0011);
    check("R9 feed ctl addr", feed_phase, 4'b0011);

    // R6 step spacing, also P=0 acts as 1
    car_interval(3, 4, gap);
    c_idx += 4;
    check("R6 gap P=3", gap, 3 * DIV);
    check("R7 done after P=3 run", car_done, 1);
    check("R5 forward 4 steps", car_phase, exp_pat(c_idx, 0, 1));
    car_interval(0, 3, gap);
    c_idx += 3;
    check("R6 gap P=0", gap, DIV);
    car_interval(5, 2, gap);
    c_idx += 2;
    check("R6 gap P=5", gap, 5 * DIV);

    // R7 done cleared by count write, exact step count
    wr(3'd2, 16'd0);
    check("R7 done cleared", car_done, 0);
    car_run(2, 5, "R7 five steps");

    // R4 mode and level deferred to next step; R3 clamp
    car_ctl(1, 0, 1, 6);
    check("R4 mode deferred", car_phase, exp_pat(c_idx, 0, 1));
    check("R4 level deferred", car_ilevel, 0);
    car_run(1, 1, "R4 one step");
    check("R3 clamp 6->4", car_ilevel, 4);
    check("R1 single pattern", car_phase, exp_pat(c_idx, 1, 1));
    car_ctl(1, 0, 1, 7);
    car_run(1, 1, "R3 clamp 7");
    check("R3 clamp 7->4", car_ilevel, 4);
    car_ctl(1, 0, 1, 2);
    car_run(1, 1, "R3 level 2");

    // R5 reverse
    car_ctl(1, 1, 1, 2);
    car_run(1, 3, "R5 reverse single");
    car_ctl(1, 1, 0, 3);
    car_run(2, 2, "R5 reverse two");

    // R8 disable: zero outputs, no stepping, index kept
    car_ctl(0, 0, 0, 3);
    check("R8 car off", car_phase, 0);
    wr(3'd1, 16'd1);
    wr(3'd2, 16'd3);
    repeat (40) @(negedge clk);
    check("R8 no steps while off", car_done, 0);
    check("R8 still zero", car_phase, 0);
    car_ctl(1, 0, 0, 3);
    check("R8 index kept", car_phase, exp_pat(c_idx, c_sa, 1));
    wait_done(1, ok);
    check("R8 resumed run done", ok, 1);
    c_idx += 3; c_sa = c_sp; c_la = c_lp;
    check("R8 resumed phase", car_phase, exp_pat(c_idx, c_sa, 1));

    // R2 feed ignores mode bit
    feed_ctl(1, 0, 1);
    feed_run(1, 3, "R2 feed mode bit");
    feed_ctl(1, 1, 1);
    feed_run(2, 5, "R2 R5 feed reverse");
    feed_ctl(0, 0, 0);
    check("R8 feed off", feed_phase, 0);
    feed_ctl(1, 0, 0);

    // random runs, both channels
    for (int it = 0; it < 24; it++) begin
      per = 1 + ($urandom % 6);
      n   = 1 + ($urandom % 9);
      if (it % 2 == 0) begin
        car_ctl(1, 1'($urandom % 2), 1'($urandom % 2), int'($urandom % 8));
        car_run(per, n, "R1 R3 R5 R7 random car");
      end else begin
        feed_ctl(1, 1'($urandom % 2), 1'($urandom % 2));
        feed_run(per, n, "R2 R5 R7 random feed");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule